// File: doc/BRIEF.md
# Secondary Bus Status Register

This block holds the status word for the parallel (conventional PCI or PCI-X) side of a bridge that joins a serial link to a parallel bus. Master and target logic on that bus report error events as single-cycle pulses. Each event sets a sticky flag that stays set until software writes a 1 to it. The same word also carries read-only capability bits. These bits are constants and are never stored.

Each flag has its own set rule. The detected-parity flag ignores the parity-response enable. The master-data-parity flag needs three conditions at once, or a split-completion parity report on its own. A received target abort on a request that expects a completion also sends a one-cycle pulse. That pulse sets the signaled-target-abort flag in the primary-side status register and marks the returned completion as target abort.

Reads are combinational from the flag registers. A flag that is set by an event becomes visible on the read port on the cycle after the clock edge that follows the event.

Top module: `sec_bus_status`

## Requirements
- R1: After reset the read value is 16'h02A0. The stored flags at bits 15, 14, 13, 12, 11 and 8 are 0. Bits 10:9 read 01b, bit 7 reads 1 and bit 5 reads 1. Bit 6 and bits 4:0 read 0.
- R2: Bit 15 sets on a parity-error event, whatever the level of the parity-response enable.
- R3: Bit 14 sets on a system-error event.
- R4: Bit 13 sets on a master-abort event or on a split-completion master-abort event.
- R5: Bit 12 sets on a received target-abort event. When the completion-required input is also high in that cycle, pri_sta_set_o is high for exactly the next cycle. Otherwise it stays low.
- R6: Bit 11 sets on a signaled target-abort event.
- R7: Bit 8 sets when the initiator-PERR event and the parity-response enable are both high. A split-completion write-parity event sets it whatever the enable. The initiator-PERR event with the enable low leaves it unchanged.
- R8: A write with wr_be_i[1]=1 clears every stored flag whose data bit is 1. Data bits at 0 leave flags unchanged. A write with wr_be_i[1]=0 changes no flag. A flag with no event and no clearing write holds its value.
- R9: When a set event and a clearing write hit the same flag in the same cycle, the flag ends set.
- R10: Writes never change the read-only or reserved bits. They always read as listed in R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| perr_resp_en_i | input | 1 | Parity-error response enable level |
| ev_parity_i | input | 1 | Address or data parity error seen on the bus |
| ev_serr_i | input | 1 | System-error assertion seen on the bus |
| ev_mst_abort_i | input | 1 | Master-abort received as initiator |
| ev_split_mabort_i | input | 1 | Split completion with master-abort status |
| ev_ta_rcvd_i | input | 1 | Target-abort received as initiator |
| ev_cpl_req_i | input | 1 | Upstream request behind ev_ta_rcvd_i expects a completion |
| ev_ta_sig_i | input | 1 | Target-abort signaled as target |
| ev_init_perr_i | input | 1 | PERR seen while the bridge is initiator |
| ev_split_wperr_i | input | 1 | Split-completion message reports write data parity error |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 16 | Write data (1 clears a flag) |
| wr_be_i | input | 2 | Byte enables, bit 1 covers bits 15:8 |
| rd_data_o | output | 16 | Register read value |
| pri_sta_set_o | output | 1 | One-cycle pulse to the primary-side signaled-target-abort flag |

## Verification
A set event and a clearing write can hit the same flag in the same cycle. The bench provokes this with directed cycles that raise an event while writing 1 to that same bit. It also provokes it in the random phase, where events and clearing writes are drawn independently on every cycle. In each case the bench judges the result against a model that applies clear-then-set, so the flag must read 1 after such a collision. The bench also drives the target-abort event together with a write that clears bit 12, and then checks both the flag and the primary-side pulse.

// File: rtl/sec_stat_pkg.sv
package sec_stat_pkg;
  localparam int unsigned DATA_W = 16;
  localparam int unsigned BE_W   = DATA_W / 8;

  localparam int unsigned B_DPE  = 15;
  localparam int unsigned B_RSE  = 14;
  localparam int unsigned B_RMA  = 13;
  localparam int unsigned B_RTA  = 12;
  localparam int unsigned B_STA  = 11;
  localparam int unsigned B_MDP  = 8;

  // stored W1C flags
  localparam logic [DATA_W-1:0] FLAG_MASK = (DATA_W'(1) << B_DPE) | (DATA_W'(1) << B_RSE) |
                                            (DATA_W'(1) << B_RMA) | (DATA_W'(1) << B_RTA) |
                                            (DATA_W'(1) << B_STA) | (DATA_W'(1) << B_MDP);
  // constant bits: devsel medium (10:9=01), fast b2b (7), 66 MHz (5)
  localparam logic [DATA_W-1:0] CONST_VAL = 16'h02A0;

  typedef struct packed {
    logic parity;
    logic serr;
    logic mst_abort;
    logic split_mabort;
    logic ta_rcvd;
    logic cpl_req;
    logic ta_sig;
    logic init_perr;
    logic split_wperr;
  } sec_ev_t;
endpackage

// File: rtl/sec_stat_set_decode.sv
module sec_stat_set_decode
  import sec_stat_pkg::*;
(
  input  sec_ev_t           ev_i,
  input  logic              perr_en_i,
  output logic [DATA_W-1:0] set_o,
  output logic              ta_cpl_o
);
  always_comb begin
    set_o        = '0;
    set_o[B_DPE] = ev_i.parity;
    set_o[B_RSE] = ev_i.serr;
    set_o[B_RMA] = ev_i.mst_abort | ev_i.split_mabort;
    set_o[B_RTA] = ev_i.ta_rcvd;
    set_o[B_STA] = ev_i.ta_sig;
    set_o[B_MDP] = (ev_i.init_perr & perr_en_i) | ev_i.split_wperr;
  end

  assign ta_cpl_o = ev_i.ta_rcvd & ev_i.cpl_req;
endmodule

// File: rtl/sec_stat_w1c_bit.sv
module sec_stat_w1c_bit (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q_o <= 1'b0;
    else if (set_i) q_o <= 1'b1;   // set wins over clear
    else if (clr_i) q_o <= 1'b0;
  end
endmodule

// File: rtl/sec_bus_status.sv
module sec_bus_status
  import sec_stat_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              perr_resp_en_i,
  input  logic              ev_parity_i,
  input  logic              ev_serr_i,
  input  logic              ev_mst_abort_i,
  input  logic              ev_split_mabort_i,
  input  logic              ev_ta_rcvd_i,
  input  logic              ev_cpl_req_i,
  input  logic              ev_ta_sig_i,
  input  logic              ev_init_perr_i,
  input  logic              ev_split_wperr_i,
  input  logic              wr_en_i,
  input  logic [15:0]       wr_data_i,
  input  logic [1:0]        wr_be_i,
  output logic [15:0]       rd_data_o,
  output logic              pri_sta_set_o
);
  sec_ev_t           ev;
  logic [DATA_W-1:0] set_vec;
  logic [DATA_W-1:0] clr_vec;
  logic [DATA_W-1:0] flag_q;
  logic              ta_cpl;

  assign ev = '{parity: ev_parity_i, serr: ev_serr_i, mst_abort: ev_mst_abort_i,
                split_mabort: ev_split_mabort_i, ta_rcvd: ev_ta_rcvd_i,
                cpl_req: ev_cpl_req_i, ta_sig: ev_ta_sig_i,
                init_perr: ev_init_perr_i, split_wperr: ev_split_wperr_i};

  sec_stat_set_decode u_dec (
    .ev_i      (ev),
    .perr_en_i (perr_resp_en_i),
    .set_o     (set_vec),
    .ta_cpl_o  (ta_cpl)
  );

  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    assign clr_vec[i] = wr_en_i & wr_be_i[i/8] & wr_data_i[i];
    if (FLAG_MASK[i]) begin : g_flag
      sec_stat_w1c_bit u_ff (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .set_i  (set_vec[i]),
        .clr_i  (clr_vec[i]),
        .q_o    (flag_q[i])
      );
    end else begin : g_const
      assign flag_q[i] = CONST_VAL[i];
    end
  end

  logic unused_bits;
  assign unused_bits = ^{set_vec & ~FLAG_MASK, clr_vec & ~FLAG_MASK};

  assign rd_data_o = flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pri_sta_set_o <= 1'b0;
    else         pri_sta_set_o <= ta_cpl;
  end
endmodule

// File: rtl/sec_bus_status_chk.sv
module sec_bus_status_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        perr_resp_en_i,
  input logic        ev_parity_i,
  input logic        ev_serr_i,
  input logic        ev_mst_abort_i,
  input logic        ev_split_mabort_i,
  input logic        ev_ta_rcvd_i,
  input logic        ev_cpl_req_i,
  input logic        ev_ta_sig_i,
  input logic        ev_init_perr_i,
  input logic        ev_split_wperr_i,
  input logic        wr_en_i,
  input logic [15:0] wr_data_i,
  input logic [1:0]  wr_be_i,
  input logic [15:0] rd_data_o,
  input logic        pri_sta_set_o
);
  logic hi_wr;
  assign hi_wr = wr_en_i & wr_be_i[1];

  assert_parity_set_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_parity_i |=> rd_data_o[15]);
  assert_serr_set_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_serr_i |=> rd_data_o[14]);
  assert_mabort_set_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_mst_abort_i || ev_split_mabort_i) |=> rd_data_o[13]);
  assert_ta_rcvd_set_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_ta_rcvd_i |=> rd_data_o[12]);
  assert_pulse_cause_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_ta_rcvd_i && ev_cpl_req_i) |=> pri_sta_set_o);
  assert_pulse_only_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ev_ta_rcvd_i && ev_cpl_req_i) |=> !pri_sta_set_o);
  assert_ta_sig_set_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_ta_sig_i |=> rd_data_o[11]);
  assert_mdp_gate_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_data_o[8] && !(ev_init_perr_i && perr_resp_en_i) && !ev_split_wperr_i) |=> !rd_data_o[8]);
  assert_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hi_wr && wr_data_i[14] && !ev_serr_i) |=> !rd_data_o[14]);
  assert_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_data_o[15] && !(hi_wr && wr_data_i[15])) |=> rd_data_o[15]);
  assert_set_wins_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hi_wr && wr_data_i[11] && ev_ta_sig_i) |=> rd_data_o[11]);
  assert_const_bits_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> (rd_data_o[10:9] == 2'b01 && rd_data_o[7] && !rd_data_o[6]
                 && rd_data_o[5] && rd_data_o[4:0] == 5'd0));
endmodule

bind sec_bus_status sec_bus_status_chk u_chk (.*);

// File: tb/sec_bus_status_test.sv
`timescale 1ns/1ps
module sec_bus_status_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        perr_resp_en_i = 1'b0;
  logic        ev_parity_i = 1'b0, ev_serr_i = 1'b0, ev_mst_abort_i = 1'b0;
  logic        ev_split_mabort_i = 1'b0, ev_ta_rcvd_i = 1'b0, ev_cpl_req_i = 1'b0;
  logic        ev_ta_sig_i = 1'b0, ev_init_perr_i = 1'b0, ev_split_wperr_i = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [15:0] wr_data_i = '0;
  logic [1:0]  wr_be_i = '0;
  logic [15:0] rd_data_o;
  logic        pri_sta_set_o;

  int n_chk = 0;
  int n_fail = 0;
  logic [15:0] m_flags = '0;
  logic        m_pulse = 1'b0;

  always #2 clk_i = ~clk_i;  // 250 MHz

  sec_bus_status uut (.*);

  task automatic check(input logic [15:0] act, input logic [15:0] exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] model_next(input logic [15:0] cur);
    logic [15:0] s, c, n;
    s = '0;
    s[15] = ev_parity_i;
    s[14] = ev_serr_i;
    s[13] = ev_mst_abort_i | ev_split_mabort_i;
    s[12] = ev_ta_rcvd_i;
    s[11] = ev_ta_sig_i;
    s[8]  = (ev_init_perr_i & perr_resp_en_i) | ev_split_wperr_i;
    c = (wr_en_i && wr_be_i[1]) ? (wr_data_i & 16'hF900) : 16'h0;
    n = (cur & ~c) | s;
    return n;
  endfunction

  task automatic idle_inputs();
    {ev_parity_i, ev_serr_i, ev_mst_abort_i, ev_split_mabort_i, ev_ta_rcvd_i,
     ev_cpl_req_i, ev_ta_sig_i, ev_init_perr_i, ev_split_wperr_i} = '0;
    wr_en_i = 1'b0; wr_data_i = '0; wr_be_i = '0;
  endtask

  // apply current inputs for one edge and check all fields
  task automatic step();
    logic [15:0] nxt;
    nxt = model_next(m_flags);
    m_pulse = ev_ta_rcvd_i & ev_cpl_req_i;
    @(posedge clk_i);
    @(negedge clk_i);
    m_flags = nxt;
    check({15'd0, rd_data_o[15]}, {15'd0, m_flags[15]}, "R2");
    check({15'd0, rd_data_o[14]}, {15'd0, m_flags[14]}, "R3");
    check({15'd0, rd_data_o[13]}, {15'd0, m_flags[13]}, "R4");
    check({15'd0, rd_data_o[12]}, {15'd0, m_flags[12]}, "R5");
    check({15'd0, pri_sta_set_o}, {15'd0, m_pulse}, "R5 pulse");
    check({15'd0, rd_data_o[11]}, {15'd0, m_flags[11]}, "R6");
    check({15'd0, rd_data_o[8]}, {15'd0, m_flags[8]}, "R7");
    check(rd_data_o & 16'hF900, m_flags & 16'hF900, "R8");
    check(rd_data_o & ~16'hF900, 16'h02A0, "R10");
    idle_inputs();
  endtask

  initial begin
    #(200000 * 4);
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk_i);
    check(rd_data_o, 16'h02A0, "R1");
    check({15'd0, pri_sta_set_o}, 16'd0, "R1");
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(rd_data_o, 16'h02A0, "R1");

    // R7: PERR as initiator with enable low does nothing
    perr_resp_en_i = 1'b0; ev_init_perr_i = 1'b1; step();
    // R7: split write parity sets regardless of enable
    ev_split_wperr_i = 1'b1; step();
    // R8: lower-byte-only write does not clear
    wr_en_i = 1'b1; wr_be_i = 2'b01; wr_data_i = 16'hFFFF; step();
    // R8: zero write leaves state; then clear
    wr_en_i = 1'b1; wr_be_i = 2'b11; wr_data_i = 16'h0000; step();
    wr_en_i = 1'b1; wr_be_i = 2'b10; wr_data_i = 16'hFFFF; step();
    // R2: parity with enable low; R5 pulse with completion required
    ev_parity_i = 1'b1; ev_ta_rcvd_i = 1'b1; ev_cpl_req_i = 1'b1; step();
    step();  // pulse must drop
    // R5 without completion: flag only
    ev_ta_rcvd_i = 1'b1; step();
    // R9: set and clear collide on every flag
    ev_parity_i = 1'b1; ev_serr_i = 1'b1; ev_split_mabort_i = 1'b1; ev_ta_rcvd_i = 1'b1;
    ev_cpl_req_i = 1'b1; ev_ta_sig_i = 1'b1; perr_resp_en_i = 1'b1; ev_init_perr_i = 1'b1;
    wr_en_i = 1'b1; wr_be_i = 2'b11; wr_data_i = 16'hFFFF; step();
    // R10: write ones to all bits, constants unchanged
    wr_en_i = 1'b1; wr_be_i = 2'b11; wr_data_i = 16'hFFFF; step();

    for (int k = 0; k < 3000; k++) begin
      perr_resp_en_i    = 1'($urandom_range(0, 1));
      ev_parity_i       = ($urandom_range(0, 7) == 0);
      ev_serr_i         = ($urandom_range(0, 7) == 0);
      ev_mst_abort_i    = ($urandom_range(0, 9) == 0);
      ev_split_mabort_i = ($urandom_range(0, 9) == 0);
      ev_ta_rcvd_i      = ($urandom_range(0, 6) == 0);
      ev_cpl_req_i      = 1'($urandom_range(0, 1));
      ev_ta_sig_i       = ($urandom_range(0, 7) == 0);
      ev_init_perr_i    = ($urandom_range(0, 5) == 0);
      ev_split_wperr_i  = ($urandom_range(0, 11) == 0);
      wr_en_i           = ($urandom_range(0, 3) == 0);
      wr_be_i           = 2'($urandom_range(0, 3));
      wr_data_i         = 16'($urandom());
      step();
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule